// File: doc/BRIEF.md
# Timer Output Compare Channel

An 8-bit timer/counter with a single output compare channel. A count register advances once per timer clock enable pulse and is compared for full-width equality against an active compare value. On a real match the block raises a sticky interrupt request flag and updates a waveform output: it sets it, clears it, toggles it or leaves it alone, as chosen by a 2-bit action field. Four counting modes are offered: free-running, clear-on-compare, fast PWM and phase-correct PWM.

A CPU-side write port reaches four registers: control, counter, compare and flag clear. In the two PWM modes a compare write lands in a buffer register. The buffer is copied to the active compare value only at the turning point of the count, so a PWM period never sees a half-applied duty value. In the two non-PWM modes the buffer is bypassed. Software can force a compare event that moves only the waveform output. Any write to the counter masks compare matches for the next timer clock pulse, so the counter can be preset to the compare value without a spurious match.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the counter, the active compare value, the waveform output and the flag are all 0, and the mode is free-running with action 00.
- R2: The write port decodes `wr_addr_i` as follows. Address 0 is control: bits 1:0 are the mode (00 free-running, 01 clear-on-compare, 10 fast PWM, 11 phase-correct PWM), bits 3:2 are the action, and bit 7 is the force strobe. Address 1 is the counter. Address 2 is the compare value. Address 3 clears the flag when bit 0 is 1.
- R3: In free-running and fast PWM modes each `tick_i` pulse adds one to the counter modulo 256. Without a pulse the counter holds.
- R4: A real match happens on a tick taken while the counter equals the active compare value and the block window is closed. A real match sets the flag and applies the action to the waveform: 00 no change, 01 toggle, 10 clear, 11 set.
- R5: In clear-on-compare mode a tick with a real match loads 0 into the counter instead of incrementing it.
- R6: In phase-correct mode the counter counts up to 0xFF, then down to 0, then up again. Each endpoint is visited once per turn, and a counter write keeps the current direction.
- R7: In the non-PWM modes a compare write reaches `cmp_o` one clock after the write.
- R8: In the PWM modes a compare write goes to the buffer and leaves `cmp_o` unchanged. The buffer is copied to `cmp_o` on the tick taken while the counter is 0xFF.
- R9: A control write with bit 7 set and a non-PWM mode in bits 1:0 applies the written action to the waveform. It leaves the flag and the counter unchanged.
- R10: The force strobe has no effect when the written mode is a PWM mode.
- R11: A counter write suppresses the match on the next tick, however many idle clocks pass before that tick. A tick in the same cycle as a counter write neither advances the counter nor compares.
- R12: Writing address 3 with bit 0 at 0 leaves the flag set. A real match in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data |
| cnt_o | output | 8 | Counter value |
| cmp_o | output | 8 | Active compare value |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Compare flag / interrupt request |

## Verification
The bench presets the counter to the compare value and then lets several idle clocks pass before the next tick. A design whose block window expired on time instead of on the next tick would set the flag there. In fast PWM and phase-correct modes it writes the compare value mid-period and checks that the old value persists until the 0xFF tick. A design without the buffer would show the new value early. It forces compare in both a non-PWM and a PWM mode: a design that sets the flag on a force, or honours a force under PWM, leaves the wrong flag or waveform. It also covers the clear-on-compare reload at 0xFF and the phase-correct turns at both ends, where an off-by-one would repeat or skip an endpoint.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_CTC   = 2'b01,
    MODE_FAST  = 2'b10,
    MODE_PHASE = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } tmr_act_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CMP  = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  localparam int unsigned FORCE_BIT = 7;

  function automatic logic is_pwm(tmr_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  tmr_mode_e    mode_i,
  input  logic         match_i,
  output logic [W-1:0] cnt_o,
  output logic         blk_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic         blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      blk_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q <= wr_data_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      blk_q <= 1'b0;
      unique case (mode_i)
        MODE_CTC: begin
          up_q  <= 1'b1;
          cnt_q <= match_i ? '0 : cnt_q + ONE;
        end
        MODE_PHASE: begin
          if (up_q) begin
            if (cnt_q == MAX) begin
              up_q  <= 1'b0;
              cnt_q <= cnt_q - ONE;
            end else cnt_q <= cnt_q + ONE;
          end else begin
            if (cnt_q == '0) begin
              up_q  <= 1'b1;
              cnt_q <= cnt_q + ONE;
            end else cnt_q <= cnt_q - ONE;
          end
        end
        default: begin
          up_q  <= 1'b1;
          cnt_q <= cnt_q + ONE;
        end
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign blk_o = blk_q;

  assert_blk_after_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> blk_o);
  assert_ctc_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && mode_i == MODE_CTC && match_i) |=> (cnt_o == '0));
  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_cmp_reg.sv
module tmr_cmp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         pwm_i,
  input  logic         load_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) buf_q <= wr_data_i;
      if (wr_i && !pwm_i)       act_q <= wr_data_i;
      else if (load_i && pwm_i) act_q <= buf_q;
    end
  end

  assign act_o = act_q;

  assert_pwm_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !load_i) |=> $stable(act_o));
  assert_direct_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pwm_i) |=> (act_o == $past(wr_data_i)));
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     event_i,
  input  tmr_act_e act_i,
  input  logic     set_flag_i,
  input  logic     clr_flag_i,
  output logic     wave_o,
  output logic     flag_o
);
  logic wave_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (set_flag_i)      flag_q <= 1'b1;
      else if (clr_flag_i) flag_q <= 1'b0;
      if (event_i) begin
        unique case (act_i)
          ACT_TOGGLE: wave_q <= ~wave_q;
          ACT_CLEAR:  wave_q <= 1'b0;
          ACT_SET:    wave_q <= 1'b1;
          default:    wave_q <= wave_q;
        endcase
      end
    end
  end

  assign wave_o = wave_q;
  assign flag_o = flag_q;

  assert_match_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flag_i |=> flag_o);
  assert_force_no_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !set_flag_i && !clr_flag_i) |=> $stable(flag_o));
  assert_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && act_i == ACT_TOGGLE) |=> (wave_o != $past(wave_o)));
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         wave_o,
  output logic         irq_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  tmr_mode_e mode_q;
  tmr_act_e  act_q;
  logic      wr_ctrl, wr_cnt, wr_cmp, wr_clr;
  logic      force_ev, match, load, blk, pwm;
  tmr_mode_e wr_mode;
  tmr_act_e  wr_act, ev_act;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_cnt  = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign wr_cmp  = wr_en_i && (wr_addr_i == ADDR_CMP);
  assign wr_clr  = wr_en_i && (wr_addr_i == ADDR_CLR) && wr_data_i[0];
  assign wr_mode = tmr_mode_e'(wr_data_i[1:0]);
  assign wr_act  = tmr_act_e'(wr_data_i[3:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FREE;
      act_q  <= ACT_NONE;
    end else if (wr_ctrl) begin
      mode_q <= wr_mode;
      act_q  <= wr_act;
    end
  end

  assign pwm      = is_pwm(mode_q);
  assign force_ev = wr_ctrl && wr_data_i[FORCE_BIT] && !is_pwm(wr_mode);
  assign match    = tick_i && !wr_cnt && !blk && (cnt_o == cmp_o);
  assign load     = tick_i && !wr_cnt && pwm && (cnt_o == MAX);
  assign ev_act   = force_ev ? wr_act : act_q;

  tmr_counter #(.W(W)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_i      (wr_cnt),
    .wr_data_i (wr_data_i),
    .mode_i    (mode_q),
    .match_i   (match),
    .cnt_o     (cnt_o),
    .blk_o     (blk)
  );

  tmr_cmp_reg #(.W(W)) i_cmp_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_cmp),
    .wr_data_i (wr_data_i),
    .pwm_i     (pwm),
    .load_i    (load),
    .act_o     (cmp_o)
  );

  tmr_wave i_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (match || force_ev),
    .act_i      (ev_act),
    .set_flag_i (match),
    .clr_flag_i (wr_clr),
    .wave_o     (wave_o),
    .flag_o     (irq_o)
  );

  assert_pwm_force_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && is_pwm(wr_mode) && !match) |=> $stable(wave_o));
  assert_clear_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !match) |=> !irq_o);
endmodule

// File: tb/test_tmr_cmp_unit.sv
module test_tmr_cmp_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] cnt_o, cmp_o;
  logic       wave_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cmp_unit i_tmr_cmp_unit (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cnt_o(cnt_o), .cmp_o(cmp_o), .wave_o(wave_o), .irq_o(irq_o)
  );

  // {mode[1:0], act[1:0], cmp[7:0], exp_wave, exp_cnt[7:0]}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {2'b00, 2'b01, 8'h20, 1'b1, 8'h21},
    {2'b00, 2'b10, 8'h40, 1'b0, 8'h41},
    {2'b00, 2'b11, 8'h7F, 1'b1, 8'h80},
    {2'b00, 2'b00, 8'h05, 1'b0, 8'h06},
    {2'b01, 2'b01, 8'h30, 1'b1, 8'h00},
    {2'b01, 2'b11, 8'hFF, 1'b1, 8'h00},
    {2'b01, 2'b10, 8'h01, 1'b0, 8'h00},
    {2'b00, 2'b01, 8'hFF, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt_o, 8'h00);
    chk("R1 cmp", cmp_o, 8'h00);
    chk("R1 wave", {7'b0, wave_o}, 8'h00);
    chk("R1 flag", {7'b0, irq_o}, 8'h00);

    // Table: R4 action codes, R5 clear-on-compare reload, R2 field decode
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 8'h88);                       // force clear, free-running
      wr(2'd3, 8'h01);
      wr(2'd0, {4'b0, VEC[i][18:17], VEC[i][20:19]});
      wr(2'd2, VEC[i][16:9]);
      wr(2'd1, VEC[i][16:9] - 8'd1);
      tick();
      chk("R4 no early flag", {7'b0, irq_o}, 8'h00);
      tick();
      chk("R4 flag on match", {7'b0, irq_o}, 8'h01);
      chk("R4 wave action", {7'b0, wave_o}, {7'b0, VEC[i][8]});
      chk("R5 count after match", cnt_o, VEC[i][7:0]);
    end

    // R3 counting and hold
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h10);
    tick(); tick(); tick();
    chk("R3 three ticks", cnt_o, 8'h13);
    idle(4);
    chk("R3 hold without tick", cnt_o, 8'h13);

    // R11 block window survives idle clocks
    wr(2'd0, 8'h88);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h04);                         // free-running, toggle
    wr(2'd2, 8'h50);
    wr(2'd1, 8'h50);
    idle(5);
    tick();
    chk("R11 blocked flag", {7'b0, irq_o}, 8'h00);
    chk("R11 blocked wave", {7'b0, wave_o}, 8'h00);
    chk("R11 count advances", cnt_o, 8'h51);
    // R11 coincident write and tick
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 8'h60; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    chk("R11 write beats tick", cnt_o, 8'h60);

    // R9 force in non-PWM mode
    wr(2'd0, 8'h84);                         // force toggle
    chk("R9 force toggles wave", {7'b0, wave_o}, 8'h01);
    chk("R9 force leaves flag", {7'b0, irq_o}, 8'h00);
    chk("R9 force leaves count", cnt_o, 8'h60);

    // R10 force ignored in fast PWM
    wr(2'd0, 8'h86);
    chk("R10 pwm force ignored", {7'b0, wave_o}, 8'h01);

    // R12 flag clear semantics
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h70);
    wr(2'd1, 8'h6F);
    tick(); tick();
    chk("R12 flag set", {7'b0, irq_o}, 8'h01);
    wr(2'd3, 8'h00);
    chk("R12 zero write keeps flag", {7'b0, irq_o}, 8'h01);
    wr(2'd3, 8'h01);
    chk("R12 one write clears flag", {7'b0, irq_o}, 8'h00);

    // R7 direct compare write
    wr(2'd2, 8'h33);
    chk("R7 direct compare", cmp_o, 8'h33);

    // R8 fast PWM buffering
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h44);
    chk("R8 buffered, old kept", cmp_o, 8'h33);
    wr(2'd1, 8'hFE);
    tick();
    chk("R8 count at top", cnt_o, 8'hFF);
    chk("R8 still old", cmp_o, 8'h33);
    tick();
    chk("R8 wrap to zero", cnt_o, 8'h00);
    chk("R8 loaded at 0xFF tick", cmp_o, 8'h44);

    // R6 phase-correct turns, R8 load at top
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h55);
    chk("R8 phase buffered", cmp_o, 8'h44);
    wr(2'd1, 8'hFE);
    tick();
    chk("R6 reach top", cnt_o, 8'hFF);
    tick();
    chk("R6 turn down", cnt_o, 8'hFE);
    chk("R8 phase load at top", cmp_o, 8'h55);
    tick();
    chk("R6 count down", cnt_o, 8'hFD);
    wr(2'd1, 8'h01);
    tick();
    chk("R6 keep direction", cnt_o, 8'h00);
    tick();
    chk("R6 turn up", cnt_o, 8'h01);
    tick();
    chk("R6 count up", cnt_o, 8'h02);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule